// File: doc/BRIEF.md
# Maskable Interrupt Controller with Trigger Modes

This block gathers up to 32 interrupt request lines from the peripherals next to a processor core and presents one interrupt request to the core. A line that is first seen high on a clock edge latches a bit in a pending-status register. The core is interrupted when at least one pending line is allowed through and the core's global interrupt enable is high. A line is allowed through when its mask bit is set. Lines 0 and 1 are always allowed through, whatever their mask bits hold. In level mode a pending bit goes away when its line drops. In edge mode the bit stays set until software clears it by writing zero to it.

Software reaches three registers through a plain address, write-data and write-enable port: the mask, a priority word, and the pending status. Read data is combinational. The priority word is plain storage and has no effect on delivery. When the controller-enable input is low, requests leave the registers alone and drive the interrupt request straight through, still gated by the global enable. Any new rising request, in either state, gives a one-cycle wake pulse that the core uses to leave its doze and sleep modes.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the mask, priority and status registers read zero, and irq_o and wake_o are low.
- R2: With ctrl_en_i high, a line sampled high on a clock edge after being sampled low on the previous edge sets its status bit at that edge. A line held high makes no new event: a status bit cleared by software while its line stays high stays clear.
- R3: With ctrl_en_i high, irq_o (registered) is high after an edge exactly when gie_i was high at that edge and, after that edge, some status bit is set whose mask bit is set or whose index is 0 or 1. A mask or enable change takes effect at the edge on which it is written.
- R4: In level mode (edge_mode_i low) a line sampled low after being sampled high clears its status bit at that edge.
- R5: In edge mode (edge_mode_i high) a status bit stays set after its line drops, until software clears it.
- R6: A write to the status register at address 2 clears every status bit written as 0 and leaves bits written as 1 unchanged; it never sets a bit. A line rising on the same edge as a clearing write ends with its bit set.
- R7: wake_o is high for exactly the one cycle after each edge on which at least one line rose, whether ctrl_en_i is high or low.
- R8: With ctrl_en_i low, requests do not change the status register, and irq_o after an edge equals gie_i AND (any req_i bit high) sampled at that edge.
- R9: The priority register at address 1 reads back what was last written and has no effect on irq_o.
- R10: Register map: address 0 is the mask, 1 the priority, 2 the status; address 3 reads zero and ignores writes. reg_rdata_o shows the addressed register with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 32 | Interrupt request lines, active high |
| ctrl_en_i | input | 1 | 1: requests go through the registers; 0: bypass |
| edge_mode_i | input | 1 | 1: edge mode, status held; 0: level mode |
| gie_i | input | 1 | Global interrupt enable from the core |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | One-cycle pulse that clears doze and sleep modes |

## Verification
On every cycle the assertions check these rules: an interrupt only follows a cycle with the global enable high; a wake pulse only follows a cycle with some request high; edge mode never loses a status bit without a clearing write; level mode drops the bit of a falling line; bypass leaves the status frozen; and a pending line 0 or 1 always interrupts when enabled. Only the bench scenarios show the exact values. These include which lines the mask blocks, the ordering between a rise and a clearing write on the same edge, the no-retrigger behaviour of a held line, the bypass interrupt level, the register map and read-back, and that the priority word has no effect.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_PRIO = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd2;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'b00,
        TRIG_EDGE   = 2'b01,
        TRIG_BYPASS = 2'b10
    } trig_mode_e;

    function automatic trig_mode_e pick_mode(input logic ctrl_en, input logic edge_mode);
        if (!ctrl_en)
            return TRIG_BYPASS;
        else if (edge_mode)
            return TRIG_EDGE;
        else
            return TRIG_LEVEL;
    endfunction

endpackage

// File: rtl/irq_line_sense.sv
module irq_line_sense #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_i,
    output logic [NLINES-1:0] line_q_o,
    output logic [NLINES-1:0] rise_o,
    output logic [NLINES-1:0] fall_o,
    output logic              wake_o
);

    typedef struct packed {
        logic [NLINES-1:0] line;
        logic              wake;
    } sense_t;

    sense_t s_d, s_q;
    logic [NLINES-1:0] rise_w, fall_w;

    // per-line transition detect against the previous sample
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign rise_w[i] = req_i[i] & ~s_q.line[i];
        assign fall_w[i] = ~req_i[i] & s_q.line[i];
    end

    always_comb begin
        s_d      = s_q;
        s_d.line = req_i;
        s_d.wake = |rise_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_q_o = s_q.line;
    assign rise_o   = rise_w;
    assign fall_o   = fall_w;
    assign wake_o   = s_q.wake;

endmodule

// File: rtl/irq_csr.sv
module irq_csr
    import irq_ctrl_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  trig_mode_e            mode_i,
    input  logic [NLINES-1:0]     rise_i,
    input  logic [NLINES-1:0]     fall_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  we_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [NLINES-1:0]     mask_d_o,
    output logic [NLINES-1:0]     stat_d_o,
    output logic [NLINES-1:0]     stat_q_o
);

    localparam int PAD_W = DATA_W - NLINES;

    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic [DATA_W-1:0] prio;
        logic [NLINES-1:0] stat;
    } csr_t;

    csr_t r_d, r_q;

    logic              wr_mask, wr_prio, wr_stat;
    logic [NLINES-1:0] keep_w;
    logic [NLINES-1:0] stat_after_clear;

    assign wr_mask = we_i && (addr_i == ADDR_MASK);
    assign wr_prio = we_i && (addr_i == ADDR_PRIO);
    assign wr_stat = we_i && (addr_i == ADDR_STAT);

    // bits written as zero are cleared, ones keep their value
    assign keep_w = wr_stat ? wdata_i[NLINES-1:0] : {NLINES{1'b1}};

    always_comb begin
        r_d = r_q;
        if (wr_mask) r_d.mask = wdata_i[NLINES-1:0];
        if (wr_prio) r_d.prio = wdata_i;

        stat_after_clear = r_q.stat & keep_w;
        unique case (mode_i)
            TRIG_LEVEL:  r_d.stat = (stat_after_clear & ~fall_i) | rise_i;
            TRIG_EDGE:   r_d.stat = stat_after_clear | rise_i;
            TRIG_BYPASS: r_d.stat = stat_after_clear;
            default:     r_d.stat = stat_after_clear;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux, no clock delay
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_MASK: rdata_o = {{PAD_W{1'b0}}, r_q.mask};
            ADDR_PRIO: rdata_o = r_q.prio;
            ADDR_STAT: rdata_o = {{PAD_W{1'b0}}, r_q.stat};
            default:   rdata_o = '0;
        endcase
    end

    assign mask_d_o = r_d.mask;
    assign stat_d_o = r_d.stat;
    assign stat_q_o = r_q.stat;

endmodule

// File: rtl/irq_deliver.sv
module irq_deliver
    import irq_ctrl_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int NFIXED = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trig_mode_e        mode_i,
    input  logic              gie_i,
    input  logic [NLINES-1:0] req_i,
    input  logic [NLINES-1:0] mask_d_i,
    input  logic [NLINES-1:0] stat_d_i,
    output logic              irq_o
);

    typedef struct packed {
        logic irq;
    } dlv_t;

    dlv_t o_d, o_q;
    logic [NLINES-1:0] pass_w;

    // lines below NFIXED pass whatever the mask holds
    for (genvar i = 0; i < NLINES; i++) begin : g_pass
        if (i < NFIXED) begin : g_fixed
            assign pass_w[i] = 1'b1;
        end else begin : g_masked
            assign pass_w[i] = mask_d_i[i];
        end
    end

    always_comb begin
        o_d = o_q;
        if (mode_i == TRIG_BYPASS)
            o_d.irq = gie_i & (|req_i);
        else
            o_d.irq = gie_i & (|(stat_d_i & pass_w));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign irq_o = o_q.irq;

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int DATA_W = 32,
    parameter int NFIXED = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLINES-1:0]     req_i,
    input  logic                  ctrl_en_i,
    input  logic                  edge_mode_i,
    input  logic                  gie_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    input  logic                  reg_we_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic                  irq_o,
    output logic                  wake_o
);

    trig_mode_e        mode;
    logic [NLINES-1:0] line_q, rise, fall;
    logic [NLINES-1:0] mask_d, stat_d, stat_q;

    assign mode = pick_mode(ctrl_en_i, edge_mode_i);

    irq_line_sense #(.NLINES(NLINES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .line_q_o (line_q),
        .rise_o   (rise),
        .fall_o   (fall),
        .wake_o   (wake_o)
    );

    irq_csr #(.NLINES(NLINES), .DATA_W(DATA_W)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .rise_i   (rise),
        .fall_i   (fall),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .we_i     (reg_we_i),
        .rdata_o  (reg_rdata_o),
        .mask_d_o (mask_d),
        .stat_d_o (stat_d),
        .stat_q_o (stat_q)
    );

    irq_deliver #(.NLINES(NLINES), .NFIXED(NFIXED)) u_dlv (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .gie_i    (gie_i),
        .req_i    (req_i),
        .mask_d_i (mask_d),
        .stat_d_i (stat_d),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int NLINES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NLINES-1:0]     req_i,
    input logic                  ctrl_en_i,
    input logic                  edge_mode_i,
    input logic                  gie_i,
    input logic [REG_ADDR_W-1:0] reg_addr_i,
    input logic                  reg_we_i,
    input logic                  irq_o,
    input logic                  wake_o,
    input logic [NLINES-1:0]     stat_q,
    input logic [NLINES-1:0]     line_q
);

    logic stat_wr;
    assign stat_wr = reg_we_i && (reg_addr_i == ADDR_STAT);

    // R3: no interrupt unless the global enable was high
    p_irq_needs_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(gie_i));

    // R7: a wake pulse needs some request high on the edge before
    p_wake_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(|req_i));

    // R5: edge mode never loses a status bit without a clearing write
    p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en_i && edge_mode_i && !stat_wr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R4: level mode drops the bit of every falling line
    p_level_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en_i && !edge_mode_i) |=> ((stat_q & $past(line_q) & ~$past(req_i)) == '0));

    // R8: bypass leaves status untouched by requests
    p_bypass_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en_i && !stat_wr) |=> $stable(stat_q));

    // R3: pending lines 0 and 1 always interrupt when enabled
    p_fixed_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en_i && edge_mode_i && gie_i && !stat_wr && (stat_q[1:0] != 2'b00)) |=> irq_o);

endmodule

bind irq_ctrl_top irq_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ctrl_en_i   (ctrl_en_i),
    .edge_mode_i (edge_mode_i),
    .gie_i       (gie_i),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .irq_o       (irq_o),
    .wake_o      (wake_o),
    .stat_q      (stat_q),
    .line_q      (line_q)
);

// File: tb/tb_irq_ctrl_top.sv
module tb_irq_ctrl_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] req_i;
    logic        ctrl_en_i, edge_mode_i, gie_i;
    logic [1:0]  reg_addr_i;
    logic [31:0] reg_wdata_i;
    logic        reg_we_i;
    logic [31:0] reg_rdata_o;
    logic        irq_o, wake_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .ctrl_en_i(ctrl_en_i), .edge_mode_i(edge_mode_i), .gie_i(gie_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_we_i(reg_we_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    typedef struct packed {
        logic        en;
        logic        edg;
        logic        gie;
        logic        we;
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic [31:0] req;
        logic        x_irq;
        logic        x_wake;
        logic [31:0] x_stat;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b1,1'b1,2'd0,32'h0000_0010,32'h0000_0000,1'b0,1'b0,32'h0000_0000}, // set mask bit4
        '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0010,1'b1,1'b1,32'h0000_0010}, // R2 rise, R3 masked in
        '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0010,1'b1,1'b0,32'h0000_0010}, // R2 held, R7 no wake
        '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0000,1'b0,1'b0,32'h0000_0000}, // R4 level drop
        '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0100,1'b0,1'b1,32'h0000_0100}, // R3 masked out
        '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0101,1'b1,1'b1,32'h0000_0101}, // R3 line0 unmaskable
        '{1'b1,1'b0,1'b0,1'b0,2'd0,32'h0,        32'h0000_0101,1'b0,1'b0,32'h0000_0101}, // R3 gie low
        '{1'b1,1'b1,1'b1,1'b0,2'd0,32'h0,        32'h0000_0001,1'b1,1'b0,32'h0000_0101}, // R5 edge keeps bit8
        '{1'b1,1'b1,1'b1,1'b0,2'd0,32'h0,        32'h0000_0000,1'b1,1'b0,32'h0000_0101}, // R5 edge keeps bit0
        '{1'b1,1'b1,1'b1,1'b1,2'd2,32'hFFFF_FEFF,32'h0000_0000,1'b1,1'b0,32'h0000_0001}, // R6 clear bit8
        '{1'b1,1'b1,1'b1,1'b1,2'd2,32'hFFFF_FFFE,32'h0000_0002,1'b1,1'b1,32'h0000_0002}, // R6 clear bit0, line1 unmaskable
        '{1'b1,1'b1,1'b1,1'b1,2'd2,32'hFFFF_FFFD,32'h0000_0002,1'b0,1'b0,32'h0000_0000}, // R6 clear bit1 while held
        '{1'b1,1'b1,1'b1,1'b0,2'd0,32'h0,        32'h0000_0002,1'b0,1'b0,32'h0000_0000}, // R2 held line no retrigger
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0006,1'b1,1'b1,32'h0000_0000}, // R8 bypass, R7 wake
        '{1'b0,1'b0,1'b0,1'b0,2'd0,32'h0,        32'h0000_0006,1'b0,1'b0,32'h0000_0000}, // R8 gie low
        '{1'b0,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0000,1'b0,1'b0,32'h0000_0000}, // R8 no request
        '{1'b1,1'b0,1'b1,1'b0,2'd0,32'h0,        32'h0000_0000,1'b0,1'b0,32'h0000_0000}, // back to level
        '{1'b1,1'b1,1'b1,1'b1,2'd2,32'h0000_0000,32'h0000_0020,1'b0,1'b1,32'h0000_0020}, // R6 rise beats clear
        '{1'b1,1'b1,1'b1,1'b1,2'd0,32'h0000_0020,32'h0000_0020,1'b1,1'b0,32'h0000_0020}  // R3 mask write same edge
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        reg_we_i   = 1'b0;
        reg_addr_i = a;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] v);
        reg_we_i    = 1'b1;
        reg_addr_i  = a;
        reg_wdata_i = v;
        @(posedge clk);
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual_cycles=%0d expected_below=5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; req_i = '0; ctrl_en_i = 1'b1; edge_mode_i = 1'b0; gie_i = 1'b0;
        reg_addr_i = '0; reg_wdata_i = '0; reg_we_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_reg(2'd0, rd); check("R1 mask", rd, 32'h0);
        read_reg(2'd1, rd); check("R1 prio", rd, 32'h0);
        read_reg(2'd2, rd); check("R1 stat", rd, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 wake", {31'b0, wake_o}, 32'h0);

        @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            ctrl_en_i = TBL[k].en; edge_mode_i = TBL[k].edg; gie_i = TBL[k].gie;
            reg_we_i = TBL[k].we; reg_addr_i = TBL[k].addr; reg_wdata_i = TBL[k].wdata;
            req_i = TBL[k].req;
            @(posedge clk);
            @(negedge clk);
            read_reg(2'd2, rd);
            check($sformatf("vec%0d irq", k), {31'b0, irq_o}, {31'b0, TBL[k].x_irq});
            check($sformatf("vec%0d wake", k), {31'b0, wake_o}, {31'b0, TBL[k].x_wake});
            check($sformatf("vec%0d stat", k), rd, TBL[k].x_stat);
        end

        // R7 wake lasts one cycle only
        @(negedge clk);
        check("R7 wake single cycle", {31'b0, wake_o}, 32'h0);

        // R10 mask readback, address 3 reads zero and ignores writes
        read_reg(2'd0, rd); check("R10 mask readback", rd, 32'h0000_0020);
        write_reg(2'd3, 32'hDEAD_BEEF);
        read_reg(2'd3, rd); check("R10 addr3 zero", rd, 32'h0);
        read_reg(2'd0, rd); check("R10 addr3 no side effect", rd, 32'h0000_0020);

        // R9 priority is storage only
        check("R9 irq before", {31'b0, irq_o}, 32'h1);
        write_reg(2'd1, 32'hFFFF_FFFF);
        read_reg(2'd1, rd); check("R9 prio readback", rd, 32'hFFFF_FFFF);
        check("R9 irq unchanged", {31'b0, irq_o}, 32'h1);
        write_reg(2'd1, 32'h0);
        check("R9 irq unchanged 0", {31'b0, irq_o}, 32'h1);

        // R3 gie toggles with pending masked status
        gie_i = 1'b0; @(posedge clk); @(negedge clk);
        check("R3 gie off", {31'b0, irq_o}, 32'h0);
        gie_i = 1'b1; @(posedge clk); @(negedge clk);
        check("R3 gie on pending", {31'b0, irq_o}, 32'h1);

        // R1 reset mid-run clears everything
        rst_n = 1'b0; @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        read_reg(2'd0, rd); check("R1 mask after reset", rd, 32'h0);
        read_reg(2'd2, rd); check("R1 stat after reset", rd, 32'h0);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule